// File: doc/BRIEF.md
# Hot-Plug Slot Command Decoder

This engine sits behind the command register of a hot-plug controller. Software writes a 16-bit command word that carries an 8-bit command code and a target slot number. The engine classifies the code and turns it into one of several actions:

- a per-slot update of the slot state, power indicator and attention indicator;
- a bus speed/mode selection;
- an operation on all slots at once;
- a rejection with an error code.

The resulting per-slot state and indicator values drive a slot register bank. Power sequencing, clock switching and blink generation happen elsewhere.

Each accepted write makes the engine busy for a fixed number of cycles. It then applies the decoded effect, or records the error, in one cycle. It pulses a completion strobe and sets a sticky command-detected flag, which software clears by writing a one. A four-bit status word reports the busy flag together with a three-bit error bitmap. Software polls this word before it issues the next command.

Top module: `hpc_cmd_engine`

## Requirements
- R1: The command word carries the code in bits [7:0] and the target slot in bits [12:8]. Codes 0x00-0x3F are slot commands made of three 2-bit subfields. Bits [1:0] give the slot state: 1 power-only, 2 enabled, 3 disabled. Bits [3:2] give the power indicator and bits [5:4] the attention indicator: 1 on, 2 blink, 3 off. Each output uses the same 2-bit encoding as its subfield, and a zero subfield leaves that item unchanged.
- R2: After reset every slot reads state 3 (disabled) with both indicators at 3 (off). The bus mode reads 0x40, and busy, the error bits, cmd_done and cmd_det are all zero.
- R3: A slot command whose target slot is at or above NUM_SLOTS reports invalid command (status[3:1] = 2) and changes no state.
- R4: A slot command whose state subfield is 1 or 2 reports switch-open (status[3:1] = 1) and changes no state when the target slot's mrl_open bit is 1. State 3 and indicator-only commands proceed regardless of mrl_open.
- R5: Code 0x48 sets every slot to power-only and code 0x49 sets every slot to enabled. Both leave the indicators unchanged and ignore the slot field. If any mrl_open bit is 1, either code reports switch-open and changes no state.
- R6: Codes 0x40-0x44 are stored as the new bus_mode. Codes 0x50-0x5D are stored only when prog_if equals 2. With any other prog_if they report invalid speed/mode (status[3:1] = 4) and leave bus_mode unchanged.
- R7: Codes 0x45-0x47, 0x4A-0x4F, 0x5E, 0x5F and 0x60-0xFF report invalid command (status[3:1] = 2) and change no state.
- R8: A write with cmd_wr high while busy is low is accepted. status[0] (busy) is then high for exactly BUSY_CYCLES cycles, starting the cycle after the accepting edge. A write made while busy is high is ignored.
- R9: The effect and the error code appear at the edge where busy falls, and cmd_done is high for the one cycle after that edge. The same edge sets cmd_det, which stays set until det_clr is sampled high; a completion in the same cycle as det_clr wins. An accepted write clears the error bits.
- R10: Code 0x3A leaves the target slot enabled with the power indicator blinking and the attention indicator off. Code 0x1F leaves it disabled with the power indicator off and the attention indicator on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Code [7:0], target slot [12:8] |
| prog_if | input | 8 | Programming interface revision (2 enables mode B) |
| mrl_open | input | NUM_SLOTS | Per-slot retention latch open |
| det_clr | input | 1 | Write-one-to-clear of cmd_det |
| cmd_status | output | 4 | {error bitmap[2:0], busy} |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_det | output | 1 | Sticky command-detected flag |
| slot_state | output | 2*NUM_SLOTS | Slot state, 2 bits per slot |
| pwr_ind | output | 2*NUM_SLOTS | Power indicator, 2 bits per slot |
| attn_ind | output | 2*NUM_SLOTS | Attention indicator, 2 bits per slot |
| bus_mode | output | 8 | Last accepted speed/mode code |

## Verification
The assertions check on every cycle that at most one error bit is set and that the completion pulse only follows a falling busy. They also check that slot outputs never move while the engine is busy and that a rejected command leaves every slot output as it was. What a given code does depends on its class, prog_if and the latch pattern. Only the bench's sweep over all 256 codes under both interface revisions can show that. The bench scenarios also cover the exact busy length, the dropping of a write made while busy, and the set-over-clear priority of the detected flag.

// File: rtl/hpc_cmd_pkg.sv
package hpc_cmd_pkg;
  localparam int CODE_W  = 8;
  localparam int SLOT_FW = 5;
  localparam int ERR_W   = 3;

  // error bitmap positions
  localparam int ERR_SW  = 0;
  localparam int ERR_CMD = 1;
  localparam int ERR_SPD = 2;

  localparam logic [1:0] ST_PWR_ONLY = 2'd1;
  localparam logic [1:0] ST_ENABLED  = 2'd2;
  localparam logic [1:0] ST_DISABLED = 2'd3;
  localparam logic [1:0] IND_OFF     = 2'd3;
  localparam logic [CODE_W-1:0] BUS_RESET = 8'h40;

  typedef struct packed {
    logic             do_slot;
    logic             do_all;
    logic [1:0]       all_st;
    logic             do_bus;
    logic [ERR_W-1:0] err;
  } hpc_action_t;
endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
  import hpc_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic [CODE_W-1:0]  code,
  input  logic [SLOT_FW-1:0] tgt,
  input  logic [7:0]         prog_if,
  input  logic [NUM_SLOTS-1:0] mrl_open,
  output hpc_action_t        act
);
  logic tgt_ok, tgt_mrl, wants_power;

  always_comb begin
    tgt_ok  = 1'b0;
    tgt_mrl = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (int'(tgt) == i) begin
        tgt_ok  = 1'b1;
        tgt_mrl = mrl_open[i];
      end
    end
  end

  assign wants_power = (code[1:0] == ST_PWR_ONLY) || (code[1:0] == ST_ENABLED);

  always_comb begin
    act = '0;
    if (code[7:6] == 2'b00) begin
      if (!tgt_ok)                  act.err[ERR_CMD] = 1'b1;
      else if (wants_power && tgt_mrl) act.err[ERR_SW] = 1'b1;
      else                          act.do_slot = 1'b1;
    end else if (code <= 8'h44) begin
      act.do_bus = 1'b1;
    end else if (code == 8'h48 || code == 8'h49) begin
      act.all_st = code[0] ? ST_ENABLED : ST_PWR_ONLY;
      if (|mrl_open) act.err[ERR_SW] = 1'b1;
      else           act.do_all = 1'b1;
    end else if (code >= 8'h50 && code <= 8'h5D) begin
      if (prog_if == 8'd2) act.do_bus = 1'b1;
      else                 act.err[ERR_SPD] = 1'b1;
    end else begin
      act.err[ERR_CMD] = 1'b1;
    end
  end

  // R7: a rejected command never also carries an action
  always_comb begin
    a_r7_err_excludes_action: assert ((act.err == '0) ||
      !(act.do_slot || act.do_all || act.do_bus));
  end
endmodule

// File: rtl/hpc_busy_timer.sv
module hpc_busy_timer #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(BUSY_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy   = busy_q;
  assign finish = busy_q && (cnt_q == '0);

  a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(cnt_q) < BUSY_CYCLES));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/hpc_slot_bank.sv
module hpc_slot_bank
  import hpc_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   apply,
  input  hpc_action_t            act,
  input  logic [CODE_W-1:0]      code,
  input  logic [SLOT_FW-1:0]     tgt,
  output logic [2*NUM_SLOTS-1:0] slot_state,
  output logic [2*NUM_SLOTS-1:0] pwr_ind,
  output logic [2*NUM_SLOTS-1:0] attn_ind
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [1:0] st_q, st_d, pw_q, pw_d, at_q, at_d;
    logic       hit;

    assign hit = apply && act.do_slot && (tgt == SLOT_FW'(g));

    always_comb begin
      st_d = st_q;
      pw_d = pw_q;
      at_d = at_q;
      if (hit) begin
        if (code[1:0] != 2'd0) st_d = code[1:0];
        if (code[3:2] != 2'd0) pw_d = code[3:2];
        if (code[5:4] != 2'd0) at_d = code[5:4];
      end else if (apply && act.do_all) begin
        st_d = act.all_st;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= ST_DISABLED;
        pw_q <= IND_OFF;
        at_q <= IND_OFF;
      end else begin
        st_q <= st_d;
        pw_q <= pw_d;
        at_q <= at_d;
      end
    end

    assign slot_state[2*g +: 2] = st_q;
    assign pwr_ind[2*g +: 2]    = pw_q;
    assign attn_ind[2*g +: 2]   = at_q;

    // R1: an update never writes the unused zero encoding
    a_r1_no_zero_state: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != 2'd0) && (pw_q != 2'd0) && (at_q != 2'd0));
  end
endmodule

// File: rtl/hpc_cmd_engine.sv
module hpc_cmd_engine
  import hpc_cmd_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int BUSY_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_wr,
  input  logic [15:0]            cmd_word,
  input  logic [7:0]             prog_if,
  input  logic [NUM_SLOTS-1:0]   mrl_open,
  input  logic                   det_clr,
  output logic [3:0]             cmd_status,
  output logic                   cmd_done,
  output logic                   cmd_det,
  output logic [2*NUM_SLOTS-1:0] slot_state,
  output logic [2*NUM_SLOTS-1:0] pwr_ind,
  output logic [2*NUM_SLOTS-1:0] attn_ind,
  output logic [7:0]             bus_mode
);
  logic                accept, busy, finish;
  logic [CODE_W-1:0]   code_q, code_d;
  logic [SLOT_FW-1:0]  tgt_q, tgt_d;
  logic [ERR_W-1:0]    err_q, err_d;
  logic [CODE_W-1:0]   bus_q, bus_d;
  logic                done_q, det_q, det_d;
  hpc_action_t         act;

  assign accept = cmd_wr && !busy;

  hpc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .finish(finish)
  );

  hpc_cmd_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
    .code(code_q), .tgt(tgt_q), .prog_if(prog_if), .mrl_open(mrl_open), .act(act)
  );

  hpc_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .apply(finish), .act(act), .code(code_q), .tgt(tgt_q),
    .slot_state(slot_state), .pwr_ind(pwr_ind), .attn_ind(attn_ind)
  );

  always_comb begin
    code_d = code_q;
    tgt_d  = tgt_q;
    err_d  = err_q;
    bus_d  = bus_q;
    det_d  = det_q;
    if (accept) begin
      code_d = cmd_word[7:0];
      tgt_d  = cmd_word[12:8];
      err_d  = '0;
    end
    if (finish) begin
      err_d = act.err;
      if (act.do_bus) bus_d = code_q;
    end
    if (finish)       det_d = 1'b1;
    else if (det_clr) det_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      tgt_q  <= '0;
      err_q  <= '0;
      bus_q  <= BUS_RESET;
      done_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      tgt_q  <= tgt_d;
      err_q  <= err_d;
      bus_q  <= bus_d;
      done_q <= finish;
      det_q  <= det_d;
    end
  end

  assign cmd_status = {err_q, busy};
  assign cmd_done   = done_q;
  assign cmd_det    = det_q;
  assign bus_mode   = bus_q;

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (!cmd_status[0] && $past(cmd_status[0])));
  a_r9_error_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_status[3:1]));
  a_r7_reject_keeps_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cmd_status[3:1] != 3'd0) |->
      (slot_state == $past(slot_state) && pwr_ind == $past(pwr_ind) &&
       attn_ind == $past(attn_ind) && bus_mode == $past(bus_mode)));
  a_r8_slots_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_status[0] && $past(cmd_status[0])) |->
      ($stable(slot_state) && $stable(pwr_ind) && $stable(attn_ind)));
  a_r9_det_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_det && !det_clr) |=> cmd_det);
endmodule

// File: tb/hpc_cmd_engine_tb.sv
`timescale 1ns/1ps
module hpc_cmd_engine_tb;
  localparam int NS = 4;
  localparam int BC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic det_clr = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [7:0]  prog_if = 8'd2;
  logic [NS-1:0] mrl_open = '0;
  logic [3:0] cmd_status;
  logic cmd_done, cmd_det;
  logic [2*NS-1:0] slot_state, pwr_ind, attn_ind;
  logic [7:0] bus_mode;

  hpc_cmd_engine #(.NUM_SLOTS(NS), .BUSY_CYCLES(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .prog_if(prog_if), .mrl_open(mrl_open), .det_clr(det_clr),
    .cmd_status(cmd_status), .cmd_done(cmd_done), .cmd_det(cmd_det),
    .slot_state(slot_state), .pwr_ind(pwr_ind), .attn_ind(attn_ind),
    .bus_mode(bus_mode)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [1:0] ms [NS];
  logic [1:0] mp [NS];
  logic [1:0] ma [NS];
  logic [7:0] mbus;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [2*NS-1:0] pk(input int which);
    logic [2*NS-1:0] v;
    for (int i = 0; i < NS; i++)
      v[2*i +: 2] = (which == 0) ? ms[i] : (which == 1) ? mp[i] : ma[i];
    return v;
  endfunction

  function automatic logic [2:0] exp_err(input int code, input int slot);
    if (code < 64) begin
      if (slot >= NS) return 3'd2;
      if (((code % 4) == 1 || (code % 4) == 2) && mrl_open[slot]) return 3'd1;
      return 3'd0;
    end
    if (code <= 'h44) return 3'd0;
    if (code == 'h48 || code == 'h49) return (mrl_open != 0) ? 3'd1 : 3'd0;
    if (code >= 'h50 && code <= 'h5D) return (prog_if == 8'd2) ? 3'd0 : 3'd4;
    return 3'd2;
  endfunction

  function automatic string tag_of(input int code);
    if (code < 64) return "R1/R3/R4";
    if (code <= 'h44) return "R6";
    if (code == 'h48 || code == 'h49) return "R5";
    if (code >= 'h50 && code <= 'h5D) return "R6";
    return "R7";
  endfunction

  task automatic cmp_model(input string tag);
    chk({tag, " slot_state"}, 32'(slot_state), 32'(pk(0)));
    chk({tag, " pwr_ind"},    32'(pwr_ind),    32'(pk(1)));
    chk({tag, " attn_ind"},   32'(attn_ind),   32'(pk(2)));
    chk({tag, " bus_mode"},   32'(bus_mode),   32'(mbus));
  endtask

  task automatic issue(input int code, input int slot, input string tag);
    logic [2:0] e;
    e = exp_err(code, slot);
    @(negedge clk);
    cmd_word = {3'b000, 5'(slot), 8'(code)};
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk({tag, " R8 busy after accept"}, 32'(cmd_status[0]), 1);
    chk({tag, " R9 error cleared on accept"}, 32'(cmd_status[3:1]), 0);
    repeat (BC - 1) @(negedge clk);
    chk({tag, " R8 busy last cycle"}, 32'(cmd_status[0]), 1);
    @(negedge clk);
    chk({tag, " R8 busy fell"}, 32'(cmd_status[0]), 0);
    chk({tag, " R9 done pulse"}, 32'(cmd_done), 1);
    chk({tag, " R9 det set"}, 32'(cmd_det), 1);
    chk({tag, " error code"}, 32'(cmd_status[3:1]), 32'(e));
    if (e == 3'd0) begin
      if (code < 64) begin
        if ((code % 4) != 0)        ms[slot] = 2'(code % 4);
        if (((code / 4) % 4) != 0)  mp[slot] = 2'((code / 4) % 4);
        if (((code / 16) % 4) != 0) ma[slot] = 2'((code / 16) % 4);
      end else if (code == 'h48 || code == 'h49) begin
        for (int i = 0; i < NS; i++) ms[i] = (code == 'h49) ? 2'd2 : 2'd1;
      end else begin
        mbus = 8'(code);
      end
    end
    cmp_model(tag);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, 32'(cmd_done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin ms[i] = 2'd3; mp[i] = 2'd3; ma[i] = 2'd3; end
    mbus = 8'h40;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 status", 32'(cmd_status), 0);
    chk("R2 done", 32'(cmd_done), 0);
    chk("R2 det", 32'(cmd_det), 0);
    cmp_model("R2");

    // R10 combined slot commands
    issue('h3A, 1, "R10 0x3A");
    chk("R10 0x3A state", 32'(slot_state[3:2]), 2);
    chk("R10 0x3A pwr", 32'(pwr_ind[3:2]), 2);
    chk("R10 0x3A attn", 32'(attn_ind[3:2]), 3);
    issue('h1F, 1, "R10 0x1F");
    chk("R10 0x1F state", 32'(slot_state[3:2]), 3);
    chk("R10 0x1F pwr", 32'(pwr_ind[3:2]), 3);
    chk("R10 0x1F attn", 32'(attn_ind[3:2]), 1);

    // R4 latch open blocks enable but not disable
    mrl_open = 4'b0100;
    issue('h02, 2, "R4 enable latch open");
    issue('h03, 2, "R4 disable latch open");
    issue('h10, 2, "R4 indicator latch open");
    issue('h49, 0, "R5 all enable latch open");
    mrl_open = '0;

    // R3 slot out of range
    issue('h02, NS, "R3 slot out of range");
    issue('h3F, 31, "R3 slot 31");

    // near-exhaustive sweep: every code, both interface revisions
    for (int p = 1; p <= 2; p++) begin
      prog_if = 8'(p);
      for (int c = 0; c < 256; c++) begin
        mrl_open = NS'((c * 7) % (1 << NS));
        issue(c, c % (NS + 1), tag_of(c));
      end
    end
    mrl_open = '0;
    prog_if = 8'd2;

    // R8 write while busy is ignored
    @(negedge clk);
    cmd_word = {3'b000, 5'd3, 8'h3A}; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_word = {3'b000, 5'd3, 8'h1F};
    @(negedge clk);
    cmd_wr = 1'b0;
    ms[3] = 2'd2; mp[3] = 2'd2; ma[3] = 2'd3;
    repeat (BC + 3) @(negedge clk);
    chk("R8 busy-write ignored busy", 32'(cmd_status[0]), 0);
    cmp_model("R8 busy-write ignored");

    // R9 det clear, and set wins over clear
    @(negedge clk); det_clr = 1'b1;
    @(negedge clk); det_clr = 1'b0;
    chk("R9 det cleared", 32'(cmd_det), 0);
    @(negedge clk);
    cmd_word = {3'b000, 5'd0, 8'h41}; cmd_wr = 1'b1; det_clr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    repeat (BC) @(negedge clk);
    chk("R9 det set wins over clear", 32'(cmd_det), 1);
    det_clr = 1'b0;
    mbus = 8'h41;
    chk("R6 bus mode 0x41", 32'(bus_mode), 32'(mbus));
    @(negedge clk);
    chk("R9 det held", 32'(cmd_det), 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule